// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block makes a pulse-width modulated waveform from a 10-bit up-counter. The counter shares its clock enable with a timer stage: an outside prescaler supplies a one-cycle `tick`, and the counter moves only on that tick. The period limit is a byte register joined with a 2-bit field of a shared 4-bit high register. The duty value is built the same way from its own byte and the other 2-bit field of that high register.

Software writes the duty byte into a master buffer. The live (slave) duty value loads only when the counter wraps at the period limit, so a new duty takes effect at the start of the next PWM cycle and the output never glitches. The period limit is used directly from the inputs and has no buffer. An enable input starts and stops the generator. A polarity input picks which output level counts as active.

Top module: `pwm10_dbuf`

## Requirements
- R1: After synchronous reset `cnt_out` is 0, the duty master byte and `duty_live` are 0, and while `pwm_en` is 0 `pwm_out` equals `pwm_pol`.
- R2: While `pwm_en` is 1, the counter goes up by one on each cycle where `tick` is 1 and the count is not the period limit. It holds on cycles where `tick` is 0.
- R3: The period limit is `{hi_cfg[3:2], prd_lo}`. On a tick where the count equals this limit, the counter returns to 0. A PWM cycle therefore lasts limit+1 ticks.
- R4: While enabled, the output is at its active level exactly when `cnt_out < duty_live`. With `pwm_pol`=0 the active level is 1.
- R5: A cycle with `duty_we`=1 stores `duty_wdata` in the master byte. `duty_live` takes `{hi_cfg[1:0], master}` only on the wrap tick of R3, or on any cycle while disabled. At all other times it holds.
- R6: A live duty value of 0 gives a constant inactive output for the whole PWM cycle.
- R7: A live duty value greater than the period limit gives a constant active output.
- R8: With `pwm_pol`=1 the output is the inverse of the `pwm_pol`=0 waveform, so the active level is 0.
- R9: While `pwm_en` is 0, `pwm_out` equals `pwm_pol` (the inactive level) and the counter is cleared to 0 on every cycle.
- R10: A change to `prd_lo` or `hi_cfg[3:2]` in the middle of a PWM cycle moves the wrap point of that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the external prescaler |
| pwm_en | input | 1 | Generator enable |
| pwm_pol | input | 1 | 1 inverts the output |
| prd_lo | input | 8 | Low byte of the period limit |
| hi_cfg | input | 4 | [3:2] period high bits, [1:0] duty high bits |
| duty_we | input | 1 | Write strobe for the duty master byte |
| duty_wdata | input | 8 | Duty low byte to store |
| cnt_out | output | 10 | Current count |
| duty_live | output | 10 | Active (slave) duty value |
| pwm_out | output | 1 | PWM waveform |

## Verification
The count, the master byte and `duty_live` are registers. Each responds one clock edge after the inputs that drive it are sampled. `pwm_out` is combinational from the count, `duty_live`, `pwm_en` and `pwm_pol`, so it follows the current register state and the current enable and polarity in the same cycle. A duty write therefore appears on `duty_live` at the first wrap tick after the write edge, and not earlier. The bench drives inputs one time unit after the rising edge. Its reference model updates on the rising edge from the values held before that drive, and every output is compared at the falling edge, which keeps the one-edge latency of the registered results.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    localparam int PWM_LO_W = 8;
    localparam int PWM_HI_W = 2;
    localparam int PWM_W    = PWM_LO_W + PWM_HI_W;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_CLEAR = 2'd1,
        CNT_STEP  = 2'd2,
        CNT_WRAP  = 2'd3
    } cnt_act_e;

    typedef struct packed {
        logic en;
        logic pol;
    } pwm_mode_t;

    function automatic logic slave_load(cnt_act_e act);
        return (act == CNT_WRAP) || (act == CNT_CLEAR);
    endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm10_pkg::*;
#(
    parameter int W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt_q,
    output cnt_act_e     act
);

    always_comb begin
        if (!en)                 act = CNT_CLEAR;
        else if (!tick)          act = CNT_HOLD;
        else if (cnt_q == limit) act = CNT_WRAP;
        else                     act = CNT_STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (act)
                CNT_CLEAR, CNT_WRAP: cnt_q <= '0;
                CNT_STEP:            cnt_q <= cnt_q + W'(1);
                default:             cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
    parameter int LO_W = pwm10_pkg::PWM_LO_W,
    parameter int HI_W = pwm10_pkg::PWM_HI_W,
    localparam int W   = LO_W + HI_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [LO_W-1:0] wdata,
    input  logic [HI_W-1:0] hi_bits,
    input  logic            load,
    output logic [W-1:0]    duty_act
);

    logic [LO_W-1:0] master_q;

    always_ff @(posedge clk) begin
        if (rst)     master_q <= '0;
        else if (we) master_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)       duty_act <= '0;
        else if (load) duty_act <= {hi_bits, master_q};
    end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm10_pkg::*;
#(
    parameter int W = PWM_W
) (
    input  pwm_mode_t    mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] duty,
    output logic         wave
);

    logic active;

    always_comb begin
        active = mode.en && (cnt < duty);
        wave   = active ^ mode.pol;
    end

endmodule

// File: rtl/pwm10_dbuf.sv
module pwm10_dbuf
    import pwm10_pkg::*;
#(
    parameter int LO_W = PWM_LO_W,
    parameter int HI_W = PWM_HI_W,
    localparam int W   = LO_W + HI_W,
    localparam int HC_W = 2 * HI_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            pwm_en,
    input  logic            pwm_pol,
    input  logic [LO_W-1:0] prd_lo,
    input  logic [HC_W-1:0] hi_cfg,
    input  logic            duty_we,
    input  logic [LO_W-1:0] duty_wdata,
    output logic [W-1:0]    cnt_out,
    output logic [W-1:0]    duty_live,
    output logic            pwm_out
);

    pwm_mode_t    mode;
    cnt_act_e     act;
    logic [W-1:0] limit;

    assign mode  = '{en: pwm_en, pol: pwm_pol};
    assign limit = {hi_cfg[HC_W-1:HI_W], prd_lo};

    pwm_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (pwm_en),
        .tick  (tick),
        .limit (limit),
        .cnt_q (cnt_out),
        .act   (act)
    );

    pwm_duty_buf #(.LO_W(LO_W), .HI_W(HI_W)) u_duty (
        .clk      (clk),
        .rst      (rst),
        .we       (duty_we),
        .wdata    (duty_wdata),
        .hi_bits  (hi_cfg[HI_W-1:0]),
        .load     (slave_load(act)),
        .duty_act (duty_live)
    );

    pwm_out_stage #(.W(W)) u_out (
        .mode (mode),
        .cnt  (cnt_out),
        .duty (duty_live),
        .wave (pwm_out)
    );

endmodule

// File: rtl/pwm10_dbuf_chk.sv
module pwm10_dbuf_chk #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         pwm_en,
    input logic         pwm_pol,
    input logic [W-1:0] limit,
    input logic [W-1:0] cnt,
    input logic [W-1:0] duty,
    input logic         wave
);

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pwm_en && tick && cnt != limit) |=> (cnt == W'($past(cnt) + 1)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (pwm_en && !tick) |=> $stable(cnt));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (pwm_en && tick && cnt == limit) |=> (cnt == '0));

    assert_slave_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (pwm_en && !(tick && cnt == limit)) |=> $stable(duty));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !pwm_en |=> (cnt == '0));

    assert_idle_level_R9: assert property (@(posedge clk) disable iff (rst)
        !pwm_en |-> (wave == pwm_pol));

    assert_zero_duty_R6: assert property (@(posedge clk) disable iff (rst)
        (pwm_en && duty == '0) |-> (wave == pwm_pol));

    assert_full_duty_R7: assert property (@(posedge clk) disable iff (rst)
        (pwm_en && duty > limit && cnt <= limit) |-> (wave != pwm_pol));

endmodule

bind pwm10_dbuf pwm10_dbuf_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .pwm_en  (pwm_en),
    .pwm_pol (pwm_pol),
    .limit   ({hi_cfg[HC_W-1:HI_W], prd_lo}),
    .cnt     (cnt_out),
    .duty    (duty_live),
    .wave    (pwm_out)
);

// File: tb/pwm10_dbuf_tb.sv
`timescale 1ns/1ps
module pwm10_dbuf_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       pwm_en = 1'b0;
    logic       pwm_pol = 1'b0;
    logic [7:0] prd_lo = 8'd0;
    logic [3:0] hi_cfg = 4'd0;
    logic       duty_we = 1'b0;
    logic [7:0] duty_wdata = 8'd0;
    logic [9:0] cnt_out;
    logic [9:0] duty_live;
    logic       pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    int tdiv    = 1;
    int tphase  = 0;
    int m_cnt = 0, m_mas = 0, m_sla = 0;
    int const_lvl = -1;
    bit run_chk = 1'b0;
    string tag_cnt  = "R2";
    string tag_out  = "R4";
    string tag_duty = "R5";

    always #4 clk = ~clk;

    pwm10_dbuf u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .pwm_en     (pwm_en),
        .pwm_pol    (pwm_pol),
        .prd_lo     (prd_lo),
        .hi_cfg     (hi_cfg),
        .duty_we    (duty_we),
        .duty_wdata (duty_wdata),
        .cnt_out    (cnt_out),
        .duty_live  (duty_live),
        .pwm_out    (pwm_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // prescaler model: tick every tdiv cycles
    always @(posedge clk) begin
        #1;
        tphase = (tphase + 1) % tdiv;
        tick = (tphase == 0);
    end

    // behavioural reference, updated from pre-edge input values
    always @(posedge clk) begin
        int prd, old;
        if (rst) begin
            m_cnt = 0; m_mas = 0; m_sla = 0;
        end else begin
            prd = int'(hi_cfg[3:2]) * 256 + int'(prd_lo);
            old = m_mas;
            if (duty_we) m_mas = int'(duty_wdata);
            if (!pwm_en) begin
                m_cnt = 0;
                m_sla = int'(hi_cfg[1:0]) * 256 + old;
            end else if (tick) begin
                if (m_cnt == prd) begin
                    m_cnt = 0;
                    m_sla = int'(hi_cfg[1:0]) * 256 + old;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        int exp_out;
        if (run_chk) begin
            exp_out = !pwm_en ? int'(pwm_pol) :
                      ((m_cnt < m_sla) ? int'(!pwm_pol) : int'(pwm_pol));
            chk(int'(cnt_out) == m_cnt, tag_cnt, int'(cnt_out), m_cnt);
            chk(int'(duty_live) == m_sla, tag_duty, int'(duty_live), m_sla);
            chk(int'(pwm_out) == exp_out, tag_out, int'(pwm_out), exp_out);
            if (const_lvl >= 0)
                chk(int'(pwm_out) == (const_lvl ? int'(!pwm_pol) : int'(pwm_pol)),
                    tag_out, int'(pwm_out), const_lvl ? int'(!pwm_pol) : int'(pwm_pol));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_duty(input logic [7:0] v);
        @(posedge clk); #1;
        duty_we = 1'b1; duty_wdata = v;
        @(posedge clk); #1;
        duty_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(cnt_out == 10'd0, "R1", int'(cnt_out), 0);
        chk(duty_live == 10'd0, "R1", int'(duty_live), 0);
        chk(pwm_out == pwm_pol, "R1", int'(pwm_out), int'(pwm_pol));
        run_chk = 1'b1;

        // R4: basic waveform, period 9, duty 4
        prd_lo = 8'd9;
        write_duty(8'd4);
        pwm_en = 1'b1;
        step(45);

        // R5: mid-cycle duty change with slower prescaler
        tdiv = 2; tag_duty = "R5";
        step(5);
        write_duty(8'd7);
        step(60);

        // R6: zero duty
        tag_out = "R6";
        write_duty(8'd0);
        step(30);
        const_lvl = 0;
        step(30);
        const_lvl = -1;

        // R7: duty above period
        tag_out = "R7";
        write_duty(8'd15);
        step(30);
        const_lvl = 1;
        step(30);
        const_lvl = -1;

        // R8: inverted polarity
        tag_out = "R8";
        pwm_pol = 1'b1;
        write_duty(8'd3);
        step(50);
        pwm_pol = 1'b0;

        // R10: period shortened mid-cycle
        tag_out = "R4"; tag_cnt = "R10"; tdiv = 1;
        prd_lo = 8'd20;
        step(30);
        while (cnt_out != 10'd5) step(1);
        prd_lo = 8'd12;
        step(50);

        // R3: high bits for period and duty
        tag_cnt = "R3"; tag_duty = "R5";
        hi_cfg = 4'b0101;
        write_duty(8'd2);
        step(900);
        hi_cfg = 4'b0000;

        // R9: disabled
        tag_cnt = "R9"; tag_out = "R9";
        pwm_en = 1'b0;
        step(10);
        pwm_pol = 1'b1;
        step(10);
        @(negedge clk);
        chk(cnt_out == 10'd0, "R9", int'(cnt_out), 0);
        chk(pwm_out == 1'b1, "R9", int'(pwm_out), 1);
        pwm_pol = 1'b0;
        tag_cnt = "R2"; tag_out = "R4";
        pwm_en = 1'b1;
        step(40);

        run_chk = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule